// File: doc/BRIEF.md
# Per-Core Interrupt Timer with Absolute Deadline

The block is a local interrupt timer for one processor core. A control register picks one of three operating modes through a two-bit field: a countdown that fires once, a countdown that reloads and fires repeatedly, and a compare mode that fires when a free-running 64-bit timestamp input reaches an absolute value held in a deadline register. Software talks to it through a single-cycle register port. Each expiry raises a one-cycle interrupt request, tagged with an 8-bit vector taken from the control register.

The sequencing is a three-state machine. `ST_IDLE` means nothing is running. `ST_COUNT` means a countdown is in progress. `ST_ARMED` means a future deadline is being compared against the timestamp. The transitions are:
- IDLE to COUNT: on a nonzero initial-count write.
- COUNT to COUNT: on a reload in periodic mode.
- COUNT to IDLE: on one-shot expiry, or on a write of zero to the initial count.
- IDLE or ARMED to ARMED: on a write of a future deadline.
- ARMED to IDLE: on expiry, on a write of zero, or on a write of a deadline that is already due.
- Any state to IDLE: on a control write that changes the mode.

Counting uses a fixed prescaler set by parameter. A control write that switches modes wipes every piece of timer state. Each mode also hides the registers that do not belong to it.

Top module: `core_timer`

## Requirements
- R1: After reset, every register reads zero, the mode is one-shot (code 0) and `irq` is low.
- R2: A control write whose mode field (bits 10:9) differs from the current mode clears the initial count, the current count and the deadline, and stops any running countdown or armed deadline. A control write that keeps the mode leaves these registers unchanged.
- R3: In deadline mode (code 2), the initial-count register (address 1) and the current-count register (address 2) read zero, and writes to the initial count are ignored.
- R4: Outside deadline mode, the deadline register (address 3) reads zero and writes to it are ignored; such a write raises no interrupt.
- R5: In one-shot mode (code 0), writing N>0 to the initial count loads the current count with N. `irq` is then high for one cycle N clock edges after the edge that accepted the write, and the current count rests at zero afterwards. Writing zero stops the count.
- R6: In periodic mode (code 1), the count reloads from the initial count on each expiry, so `irq` pulses every N edges until zero is written to the initial count.
- R7: In deadline mode, writing a value above `tsc` stores it and arms the timer. `irq` pulses after the first edge at which `tsc` is at least the stored value, and the deadline then reads zero.
- R8: In deadline mode, writing a nonzero value at or below `tsc` leaves the deadline at zero and pulses `irq` after the accepting edge.
- R9: In deadline mode, writing zero clears the deadline and disarms the timer with no interrupt.
- R10: Writing a new future deadline while one is armed replaces it, and only the new value fires.
- R11: With the mask bit (bit 8) set, no `irq` is raised. An armed deadline still clears to zero on expiry.
- R12: `irq_vector` equals control bits 7:0 while `irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 initial count, 2 current count, 3 deadline |
| wdata | input | TS_W | Write data |
| rdata | output | TS_W | Read data for `addr`, combinational |
| tsc | input | TS_W | Free-running timestamp |
| irq | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
A corrupt mode field or stale state register shows up within one edge as a wrong gated read: a count visible in deadline mode, or a deadline visible outside it. It can also show up as an interrupt from a write that should have been ignored. A countdown or compare that runs after it should have been cleared shows up as an interrupt that the scoreboard did not expect, at the cycle the stale value expires. An off-by-one in the count or the compare moves the pulse by exactly one cycle, and the per-cycle scoreboard catches that directly.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
    localparam int CTRL_W   = 11;
    localparam int VEC_W    = 8;
    localparam int MASK_BIT = 8;
    localparam int MODE_LSB = 9;

    typedef enum logic [1:0] {
        M_ONESHOT  = 2'd0,
        M_PERIODIC = 2'd1,
        M_DEADLINE = 2'd2,
        M_RSVD     = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_INIT = 2'd1,
        A_CUR  = 2'd2,
        A_DL   = 2'd3
    } addr_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ARMED = 2'd2
    } state_e;
endpackage

// File: rtl/ltmr_prescale.sv
module ltmr_prescale #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ltmr_cmp.sv
module ltmr_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         ge
);
    assign ge = (a >= b);
endmodule

// File: rtl/ltmr_regread.sv
module ltmr_regread
    import ltmr_pkg::*;
#(
    parameter int TS_W  = 64,
    parameter int CNT_W = 32
) (
    input  logic [1:0]        addr,
    input  mode_e             mode,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [CNT_W-1:0]  init_cnt,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic [TS_W-1:0]   dl,
    output logic [TS_W-1:0]   rdata
);
    logic cnt_vis;
    logic dl_vis;

    always_comb begin
        cnt_vis = (mode == M_ONESHOT) || (mode == M_PERIODIC);
        dl_vis  = (mode == M_DEADLINE);
        unique case (addr)
            A_CTRL:  rdata = TS_W'(ctrl);
            A_INIT:  rdata = cnt_vis ? TS_W'(init_cnt) : '0;
            A_CUR:   rdata = cnt_vis ? TS_W'(cur_cnt) : '0;
            default: rdata = dl_vis ? dl : '0;
        endcase
    end
endmodule

// File: rtl/core_timer.sv
module core_timer
    import ltmr_pkg::*;
#(
    parameter int TS_W  = 64,
    parameter int CNT_W = 32,
    parameter int DIV   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [TS_W-1:0] wdata,
    output logic [TS_W-1:0] rdata,
    input  logic [TS_W-1:0] tsc,
    output logic            irq,
    output logic [7:0]      irq_vector
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    state_e            state_q, state_n;
    logic [CTRL_W-1:0] ctrl_q, ctrl_n;
    logic [CNT_W-1:0]  init_q, init_n;
    logic [CNT_W-1:0]  cur_q, cur_n;
    logic [TS_W-1:0]   dl_q, dl_n;
    logic              irq_q;
    logic              fire;
    logic              tick;
    logic              tsc_ge_dl;
    logic              tsc_ge_wr;
    mode_e             mode_q, mode_wr;
    logic              cnt_mode;

    assign mode_q   = mode_e'(ctrl_q[MODE_LSB +: 2]);
    assign mode_wr  = mode_e'(wdata[MODE_LSB +: 2]);
    assign cnt_mode = (mode_q == M_ONESHOT) || (mode_q == M_PERIODIC);

    ltmr_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));
    ltmr_cmp #(.W(TS_W)) u_cmp_exp (.a(tsc), .b(dl_q),  .ge(tsc_ge_dl));
    ltmr_cmp #(.W(TS_W)) u_cmp_wr  (.a(tsc), .b(wdata), .ge(tsc_ge_wr));
    ltmr_regread #(.TS_W(TS_W), .CNT_W(CNT_W)) u_rd (
        .addr(addr), .mode(mode_q), .ctrl(ctrl_q), .init_cnt(init_q),
        .cur_cnt(cur_q), .dl(dl_q), .rdata(rdata)
    );

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
            init_q  <= '0;
            cur_q   <= '0;
            dl_q    <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            ctrl_q  <= ctrl_n;
            init_q  <= init_n;
            cur_q   <= cur_n;
            dl_q    <= dl_n;
            irq_q   <= fire & ~ctrl_q[MASK_BIT];
        end
    end

    // Next state: timer progress first, register writes take precedence
    always_comb begin
        state_n = state_q;
        ctrl_n  = ctrl_q;
        init_n  = init_q;
        cur_n   = cur_q;
        dl_n    = dl_q;
        fire    = 1'b0;

        unique case (state_q)
            ST_IDLE: ;
            ST_COUNT: begin
                if (tick) begin
                    if (cur_q == ONE) begin
                        fire = 1'b1;
                        if (mode_q == M_PERIODIC) begin
                            cur_n = init_q;
                        end else begin
                            cur_n   = '0;
                            state_n = ST_IDLE;
                        end
                    end else begin
                        cur_n = cur_q - ONE;
                    end
                end
            end
            ST_ARMED: begin
                if (tsc_ge_dl) begin
                    fire    = 1'b1;
                    dl_n    = '0;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase

        if (wr_en) begin
            unique case (addr)
                A_CTRL: begin
                    ctrl_n = wdata[CTRL_W-1:0];
                    if (mode_wr != mode_q) begin
                        init_n  = '0;
                        cur_n   = '0;
                        dl_n    = '0;
                        state_n = ST_IDLE;
                        fire    = 1'b0;
                    end
                end
                A_INIT: begin
                    if (cnt_mode) begin
                        init_n  = wdata[CNT_W-1:0];
                        cur_n   = wdata[CNT_W-1:0];
                        fire    = 1'b0;
                        state_n = (wdata[CNT_W-1:0] != '0) ? ST_COUNT : ST_IDLE;
                    end
                end
                A_DL: begin
                    if (mode_q == M_DEADLINE) begin
                        if (!tsc_ge_wr) begin
                            dl_n    = wdata;
                            state_n = ST_ARMED;
                            fire    = 1'b0;
                        end else begin
                            dl_n    = '0;
                            state_n = ST_IDLE;
                            fire    = (wdata != '0);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        irq        = irq_q;
        irq_vector = ctrl_q[VEC_W-1:0];
    end

    assert_mode_change_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && mode_wr != mode_q)
        |=> (init_q == '0 && cur_q == '0 && dl_q == '0 && state_q == ST_IDLE));

    assert_counts_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_DEADLINE && (addr == A_INIT || addr == A_CUR)) |-> rdata == '0);

    assert_deadline_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != M_DEADLINE && addr == A_DL) |-> rdata == '0);

    assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && mode_q == M_ONESHOT && tick && cur_q == ONE && !wr_en)
        |=> (state_q == ST_IDLE && irq == !$past(ctrl_q[MASK_BIT])));

    assert_armed_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> dl_q != '0);

    assert_zero_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DL && mode_q == M_DEADLINE && wdata == '0)
        |=> (!irq && dl_q == '0 && state_q == ST_IDLE));

    assert_mask_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(ctrl_q[MASK_BIT]));
endmodule

// File: tb/core_timer_bench.sv
module core_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [63:0] tsc = 64'd1000;
    logic        irq;
    logic [7:0]  irq_vector;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int last_acc = 0;
    bit done = 1'b0;

    int       exp_cyc[$];
    bit [7:0] exp_vec[$];
    string    exp_req[$];

    core_timer u_core_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tsc(tsc), .irq(irq), .irq_vector(irq_vector)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] ctl(input logic [7:0] vec, input logic msk,
                                        input logic [1:0] mode);
        return {53'd0, mode, msk, vec};
    endfunction

    task automatic push(input int c, input logic [7:0] v, input string r);
        exp_cyc.push_back(c);
        exp_vec.push_back(v);
        exp_req.push_back(r);
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        last_acc = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [1:0] a, input logic [63:0] e, input string r);
        addr = a;
        #1;
        checks++;
        if (rdata !== e) begin
            fails++;
            $display("FAIL %s: addr %0d read %0d expected %0d", r, a, rdata, e);
        end
    endtask

    // Monitor: compare each interrupt pulse with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (irq) begin
                checks++;
                if (exp_cyc.size() == 0) begin
                    fails++;
                    $display("FAIL R4/R9/R11: unexpected irq at edge %0d (actual 1, expected 0)", cyc);
                end else begin
                    if (exp_cyc[0] != cyc || exp_vec[0] != irq_vector) begin
                        fails++;
                        $display("FAIL %s/R12: irq at edge %0d vec %h, expected edge %0d vec %h",
                                 exp_req[0], cyc, irq_vector, exp_cyc[0], exp_vec[0]);
                    end
                    void'(exp_cyc.pop_front());
                    void'(exp_vec.pop_front());
                    void'(exp_req.pop_front());
                end
            end else if (exp_cyc.size() != 0 && exp_cyc[0] < cyc) begin
                checks++;
                fails++;
                $display("FAIL %s: no irq at edge %0d (actual 0, expected 1)", exp_req[0], exp_cyc[0]);
                void'(exp_cyc.pop_front());
                void'(exp_vec.pop_front());
                void'(exp_req.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(2'd0, 64'd0, "R1");
        chk(2'd1, 64'd0, "R1");
        chk(2'd2, 64'd0, "R1");
        chk(2'd3, 64'd0, "R1");
        checks++;
        if (irq !== 1'b0) begin
            fails++;
            $display("FAIL R1: irq %b expected 0", irq);
        end

        // R5 one-shot
        wr(2'd0, ctl(8'h41, 1'b0, 2'd0));
        wr(2'd1, 64'd5);
        push(last_acc + 5, 8'h41, "R5");
        chk(2'd2, 64'd5, "R5");
        idle(7);
        chk(2'd2, 64'd0, "R5");
        chk(2'd1, 64'd5, "R5");
        // R2 same-mode control write keeps counts
        wr(2'd0, ctl(8'h44, 1'b0, 2'd0));
        chk(2'd1, 64'd5, "R2");

        // R6 periodic (mode change clears, R2)
        wr(2'd0, ctl(8'h52, 1'b0, 2'd1));
        chk(2'd1, 64'd0, "R2");
        chk(2'd2, 64'd0, "R2");
        wr(2'd1, 64'd4);
        push(last_acc + 4, 8'h52, "R6");
        push(last_acc + 8, 8'h52, "R6");
        push(last_acc + 12, 8'h52, "R6");
        idle(12);
        wr(2'd1, 64'd0);
        idle(8);

        // R3 deadline mode hides counts
        wr(2'd0, ctl(8'h60, 1'b0, 2'd2));
        chk(2'd1, 64'd0, "R3");
        wr(2'd1, 64'd7);
        chk(2'd1, 64'd0, "R3");
        chk(2'd2, 64'd0, "R3");
        idle(3);

        // R7 future deadline
        wr(2'd3, 64'd1006);
        chk(2'd3, 64'd1006, "R7");
        tsc = 64'd1005;
        idle(2);
        tsc = 64'd1006;
        push(cyc + 1, 8'h60, "R7");
        idle(2);
        chk(2'd3, 64'd0, "R7");

        // R10 replacement
        wr(2'd3, 64'd2000);
        wr(2'd3, 64'd1010);
        chk(2'd3, 64'd1010, "R10");
        tsc = 64'd1010;
        push(cyc + 1, 8'h60, "R10");
        idle(2);
        tsc = 64'd2000;
        idle(3);
        chk(2'd3, 64'd0, "R10");

        // R8 past and equal deadlines
        tsc = 64'd3000;
        push(cyc + 1, 8'h60, "R8");
        wr(2'd3, 64'd2500);
        chk(2'd3, 64'd0, "R8");
        idle(2);
        push(cyc + 1, 8'h60, "R8");
        wr(2'd3, 64'd3000);
        chk(2'd3, 64'd0, "R8");
        idle(2);

        // R9 zero disarms
        wr(2'd3, 64'd3500);
        chk(2'd3, 64'd3500, "R9");
        wr(2'd3, 64'd0);
        chk(2'd3, 64'd0, "R9");
        tsc = 64'd4000;
        idle(4);

        // R11 masked expiry
        wr(2'd0, ctl(8'h60, 1'b1, 2'd2));
        wr(2'd3, 64'd4010);
        chk(2'd3, 64'd4010, "R11");
        tsc = 64'd4010;
        idle(3);
        chk(2'd3, 64'd0, "R11");
        wr(2'd3, 64'd100);
        idle(3);

        // R2 mode change stops an armed deadline
        wr(2'd0, ctl(8'h60, 1'b0, 2'd2));
        wr(2'd3, 64'd5000);
        wr(2'd0, ctl(8'h52, 1'b0, 2'd1));
        chk(2'd2, 64'd0, "R2");
        tsc = 64'd6000;
        idle(3);

        // R4 deadline writes ignored outside deadline mode
        wr(2'd0, ctl(8'h41, 1'b0, 2'd0));
        wr(2'd3, 64'd10);
        idle(3);
        chk(2'd3, 64'd0, "R4");
        wr(2'd0, ctl(8'h60, 1'b0, 2'd2));
        chk(2'd3, 64'd0, "R4");
        idle(3);

        checks++;
        if (exp_cyc.size() != 0) begin
            fails++;
            $display("FAIL R12: %0d expected irq left pending (expected 0)", exp_cyc.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule